// File: doc/BRIEF.md
# Store Path to an AHB-Lite Write Master

This block sits between the store side of a processor's load/store unit and an AHB-Lite bus, acting as the write master. Each request carries an address, a size code (byte, halfword or word) and right-justified write data. A naturally aligned store leaves as a single write transfer with the matching transfer size. A misaligned store is handled by a per-region attribute register: in a region marked free of side effects (idempotent), the store is split into single-byte writes issued back to back in ascending address order. In a region marked as having side effects, the store raises a misalignment exception and never reaches the bus.

Every store that uses the bus ends with one forced idle bus cycle, in which the block reports completion (or a bus error) to the requester. Completion is never signalled before the write response of the last data phase has been received. The attribute register is written by software through a simple load strobe. It is read when a request is accepted, so the same address can be split before a reconfiguration and rejected after it. While a store, its trailing idle cycle or its exception report is in progress, the block holds off new requests.

Top module: `st_ahb_store`

## Requirements
- R1: An aligned store is issued as exactly one NONSEQ write transfer (HTRANS=2'b10) with the request address, HSIZE equal to the effective size code, and the data shifted onto the byte lanes chosen by the low address bits (lanes outside the access are zero). The response cycle that follows drives HTRANS=IDLE (2'b00), so at least one idle cycle separates the last transfer of one store from the first transfer of the next.
- R2: A misaligned store to an idempotent region is issued as one NONSEQ transfer per byte with HSIZE=0, at addresses base, base+1, ... in ascending order. Data byte k of the request goes on lane (base+k) mod 4, and the other lanes are zero. When HREADY is high, each beat's address phase follows the previous one in the next cycle.
- R3: A misaligned store to a region whose attribute bit is 1 produces no bus transfer. It is answered with a response pulse that carries the misalignment flag and no bus error flag.
- R4: Size code 0 is byte, 1 is halfword and 2 is word, and code 3 is treated as a word. A byte store is always aligned, a halfword is aligned when address bit 0 is 0, and a word is aligned when address bits [1:0] are 0.
- R5: The 16-bit attribute register is loaded from the configuration data when the load strobe is high. Bit i governs addresses whose bits [31:28] equal i, and 1 means side effects. It resets to all zeros (every region idempotent). The value held when a request is accepted decides that request.
- R6: The response pulse of a store that used the bus comes in the cycle right after the final data phase has completed (HREADY high).
- R7: If HRESP reports an error on any data phase, no further beats of that store are issued. The block completes the two-cycle error response, then gives a response pulse with the bus error flag set and the misalignment flag clear, and returns to accepting requests.
- R8: The request ready output is high only when the block is idle. It is low from the cycle after acceptance through the response cycle, and it is high with the bus idle and no response after reset.
- R9: While HREADY is low, the pending address phase keeps its address and the pending data phase keeps HWDATA. With n wait states on each data phase, consecutive beats of a split store are 1+n cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load strobe for the region attribute register |
| cfg_side_fx | input | 16 | New attribute value, one side-effect bit per region |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Block can accept a store request |
| st_addr | input | 32 | Store byte address |
| st_size | input | 2 | Size code: 0 byte, 1 halfword, 2 or 3 word |
| st_data | input | 32 | Right-justified store data |
| done_valid | output | 1 | One-cycle response pulse |
| done_bus_err | output | 1 | Response carries a bus error |
| done_misalign | output | 1 | Response carries a misalignment exception |
| haddr | output | 32 | Bus address |
| htrans | output | 2 | Bus transfer type (IDLE or NONSEQ) |
| hwrite | output | 1 | Bus write indicator |
| hsize | output | 3 | Bus transfer size |
| hwdata | output | 32 | Bus write data |
| hready | input | 1 | Bus transfer done / wait-state indicator |
| hresp | input | 1 | Bus error response |

## Verification
The bench sweeps every size code over every low-address offset, in regions set to both attribute values, with and without a wait state on every data phase. This covers the lane placement of aligned halfwords in the upper half of a word and split words that cross a word boundary. A design with a wrong alignment rule would split or reject an aligned store, and one that ignored the attribute bit would put a misaligned store to a side-effect region on the bus. Error responses are injected on the first, a middle and the last byte of split stores and on an aligned word. A design that kept issuing beats after the error, reported completion too early or stayed stuck would show extra transfers, a misplaced response pulse or a hang on the following store. Reconfiguring one region between two identical stores shows that the attribute is read per request and that its reset value is all idempotent.

// File: rtl/st_ahb_pkg.sv
package st_ahb_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BUS  = 2'd1,
      ST_GAP  = 2'd2,
      ST_MIS  = 2'd3
   } stw_state_e;

   localparam logic [1:0] HTRANS_IDLE   = 2'b00;
   localparam logic [1:0] HTRANS_NONSEQ = 2'b10;
   localparam logic [2:0] HSIZE_BYTE    = 3'd0;

endpackage

// File: rtl/st_ahb_region_attr.sv
module st_ahb_region_attr #(
   parameter  int RB = 4,
   localparam int NR = 1 << RB
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [NR-1:0] cfg_side_fx,
   input  logic [RB-1:0] region_idx,
   output logic          side_fx
);

   generate
      if (RB < 1 || RB > 8) begin : g_bad_rb
         $error("st_ahb_region_attr: RB must lie in 1..8");
      end
   endgenerate

   logic [NR-1:0] attr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      attr_q <= '0;
      else if (cfg_we) attr_q <= cfg_side_fx;
   end

   assign side_fx = attr_q[region_idx];

   AST_ATTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> attr_q == $past(cfg_side_fx)) else $error("attr load"); // R5

   AST_ATTR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(attr_q)) else $error("attr keep"); // R5

endmodule

// File: rtl/st_ahb_align_chk.sv
module st_ahb_align_chk #(
   parameter  int DW = 32,
   localparam int NL = DW / 8,
   localparam int LG = $clog2(NL)
) (
   input  logic [1:0]    size_code,
   input  logic [LG-1:0] addr_lo,
   output logic [2:0]    size_eff,
   output logic [LG-1:0] nbm1,
   output logic          unal
);

   generate
      if (DW < 16 || (DW % 8) != 0 || (1 << LG) != NL) begin : g_bad_dw
         $error("st_ahb_align_chk: DW must be a power-of-two byte count of at least 16");
      end
   endgenerate

   int sc;

   always_comb begin
      sc       = (int'(size_code) > LG) ? LG : int'(size_code);
      size_eff = 3'(sc);
      nbm1     = LG'((1 << sc) - 1);
      unal     = |(addr_lo & nbm1);
   end

endmodule

// File: rtl/st_ahb_lane_place.sv
module st_ahb_lane_place #(
   parameter  int DW = 32,
   localparam int NL = DW / 8,
   localparam int LG = $clog2(NL)
) (
   input  logic [DW-1:0] src,
   input  logic [LG-1:0] off,
   input  logic [LG-1:0] nbm1,
   output logic [DW-1:0] lanes
);

   logic [DW-1:0] shifted;

   assign shifted = src << {off, 3'b000};

   generate
      for (genvar i = 0; i < NL; i++) begin : g_lane
         logic hit;
         always_comb hit = (i >= int'(off)) && ((i - int'(off)) <= int'(nbm1));
         assign lanes[8*i +: 8] = hit ? shifted[8*i +: 8] : 8'h00;
      end
   endgenerate

endmodule

// File: rtl/st_ahb_store.sv
module st_ahb_store
   import st_ahb_pkg::*;
#(
   parameter  int AW = 32,
   parameter  int DW = 32,
   parameter  int RB = 4,
   localparam int NR = 1 << RB,
   localparam int NL = DW / 8,
   localparam int LG = $clog2(NL)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [NR-1:0] cfg_side_fx,
   input  logic          st_valid,
   output logic          st_ready,
   input  logic [AW-1:0] st_addr,
   input  logic [1:0]    st_size,
   input  logic [DW-1:0] st_data,
   output logic          done_valid,
   output logic          done_bus_err,
   output logic          done_misalign,
   output logic [AW-1:0] haddr,
   output logic [1:0]    htrans,
   output logic          hwrite,
   output logic [2:0]    hsize,
   output logic [DW-1:0] hwdata,
   input  logic          hready,
   input  logic          hresp
);

   generate
      if (AW < RB + LG) begin : g_bad_aw
         $error("st_ahb_store: AW too small for region and lane bits");
      end
   endgenerate

   stw_state_e    st_q;
   logic [AW-1:0] base_q;
   logic [DW-1:0] data_q;
   logic [2:0]    hsize_q;
   logic [LG-1:0] nbm1_q, last_q, a_idx, d_idx;
   logic          split_q, a_act, d_act, err_q;

   logic [2:0]    al_size;
   logic [LG-1:0] al_nbm1;
   logic          al_unal, fx_hit;

   st_ahb_region_attr #(.RB(RB)) u_attr (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_we      (cfg_we),
      .cfg_side_fx (cfg_side_fx),
      .region_idx  (st_addr[AW-1 -: RB]),
      .side_fx     (fx_hit)
   );

   st_ahb_align_chk #(.DW(DW)) u_align (
      .size_code (st_size),
      .addr_lo   (st_addr[LG-1:0]),
      .size_eff  (al_size),
      .nbm1      (al_nbm1),
      .unal      (al_unal)
   );

   logic abort, issue;
   assign abort = d_act && hresp;
   assign issue = a_act && !abort;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         base_q  <= '0;
         data_q  <= '0;
         hsize_q <= '0;
         nbm1_q  <= '0;
         last_q  <= '0;
         split_q <= 1'b0;
         a_act   <= 1'b0;
         d_act   <= 1'b0;
         a_idx   <= '0;
         d_idx   <= '0;
         err_q   <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (st_valid) begin
                  base_q  <= st_addr;
                  data_q  <= st_data;
                  hsize_q <= al_size;
                  nbm1_q  <= al_nbm1;
                  split_q <= al_unal;
                  last_q  <= al_unal ? al_nbm1 : '0;
                  err_q   <= 1'b0;
                  a_idx   <= '0;
                  d_act   <= 1'b0;
                  if (al_unal && fx_hit) begin
                     st_q <= ST_MIS;
                  end else begin
                     a_act <= 1'b1;
                     st_q  <= ST_BUS;
                  end
               end
            end
            ST_BUS: begin
               if (abort) err_q <= 1'b1;
               if (hready) begin
                  d_act <= issue;
                  d_idx <= a_idx;
                  if (abort) begin
                     a_act <= 1'b0;
                  end else if (a_act) begin
                     if (a_idx == last_q) a_act <= 1'b0;
                     else                 a_idx <= a_idx + 1'b1;
                  end
                  if (!issue) st_q <= ST_GAP;
               end
            end
            ST_GAP, ST_MIS: st_q <= ST_IDLE;
            default:        st_q <= ST_IDLE;
         endcase
      end
   end

   // Bus side
   logic [LG-1:0] d_lo;
   logic [DW-1:0] lane_src;
   logic [LG-1:0] lane_off, lane_nbm1;

   assign d_lo      = base_q[LG-1:0] + d_idx;
   assign lane_src  = split_q ? (data_q >> {d_idx, 3'b000}) : data_q;
   assign lane_off  = split_q ? d_lo : base_q[LG-1:0];
   assign lane_nbm1 = split_q ? '0 : nbm1_q;

   st_ahb_lane_place #(.DW(DW)) u_lanes (
      .src   (lane_src),
      .off   (lane_off),
      .nbm1  (lane_nbm1),
      .lanes (hwdata)
   );

   assign htrans = (st_q == ST_BUS && issue) ? HTRANS_NONSEQ : HTRANS_IDLE;
   assign hwrite = (htrans == HTRANS_NONSEQ);
   assign haddr  = split_q ? (base_q + AW'(a_idx)) : base_q;
   assign hsize  = split_q ? HSIZE_BYTE : hsize_q;

   // Requester side
   assign st_ready      = (st_q == ST_IDLE);
   assign done_valid    = (st_q == ST_GAP) || (st_q == ST_MIS);
   assign done_bus_err  = (st_q == ST_GAP) && err_q;
   assign done_misalign = (st_q == ST_MIS);

   AST_DONE_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> htrans == HTRANS_IDLE) else $error("no idle on done"); // R1

   AST_SPLIT_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
      (htrans == HTRANS_NONSEQ && hsize == HSIZE_BYTE &&
       $past(htrans == HTRANS_NONSEQ && hready))
      |-> haddr == $past(haddr) + AW'(1)) else $error("split order"); // R2

   AST_MIS_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && done_misalign)
      |-> (htrans == HTRANS_IDLE && $past(htrans) == HTRANS_IDLE)) else $error("misalign on bus"); // R3

   AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> !(done_bus_err && done_misalign)) else $error("both flags"); // R7

   AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (d_act && hresp && hready) |=> (htrans == HTRANS_IDLE && done_valid)) else $error("beat after error"); // R7

   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (htrans != HTRANS_IDLE || done_valid) |-> !st_ready) else $error("ready while busy"); // R8

   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (htrans == HTRANS_NONSEQ && !hready) |=> $stable(haddr)) else $error("addr moved"); // R9

   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (d_act && !hready) |=> $stable(hwdata)) else $error("data moved"); // R9

endmodule

// File: tb/st_ahb_store_tb_top.sv
`timescale 1ns/1ps
module st_ahb_store_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [15:0] cfg_side_fx = '0;
   logic        st_valid = 1'b0;
   logic        st_ready;
   logic [31:0] st_addr = '0;
   logic [1:0]  st_size = '0;
   logic [31:0] st_data = '0;
   logic        done_valid, done_bus_err, done_misalign;
   logic [31:0] haddr;
   logic [1:0]  htrans;
   logic        hwrite;
   logic [2:0]  hsize;
   logic [31:0] hwdata;
   logic        hready = 1'b1;
   logic        hresp = 1'b0;

   always #2.5 clk = ~clk;

   st_ahb_store dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_side_fx(cfg_side_fx),
      .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
      .st_size(st_size), .st_data(st_data),
      .done_valid(done_valid), .done_bus_err(done_bus_err), .done_misalign(done_misalign),
      .haddr(haddr), .htrans(htrans), .hwrite(hwrite), .hsize(hsize),
      .hwdata(hwdata), .hready(hready), .hresp(hresp)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // Slave model and monitor
   int          cyc = 0;
   bit          dp_pend = 0;
   int          dp_beat = 0;
   int          waits_left = 0;
   int          err_phase = 0;
   int          wait_cfg = 0;
   int          err_at = 99;
   int          n_tr = 0;
   logic [31:0] tr_addr [16];
   logic [2:0]  tr_size [16];
   logic [31:0] tr_data [16];
   int          tr_cyc  [16];
   int          last_dp_cyc = 0;
   bit          rsp_seen = 0, rsp_be = 0, rsp_ma = 0;
   int          rsp_cyc = 0;
   bit          busy = 0;
   int          ready_viol = 0;

   always @(negedge clk) begin
      if (!rst_n) begin
         hready = 1'b1; hresp = 1'b0; dp_pend = 0; err_phase = 0;
      end else begin
         if (err_phase == 1) begin
            hready = 1'b1; hresp = 1'b1; err_phase = 2;
         end else if (dp_pend && dp_beat == err_at) begin
            hready = 1'b0; hresp = 1'b1; err_phase = 1;
         end else if (dp_pend && waits_left > 0) begin
            hready = 1'b0; hresp = 1'b0; waits_left--;
         end else begin
            hready = 1'b1; hresp = 1'b0;
         end
         #1;
         cyc++;
         if (busy && st_ready) ready_viol++;
         if (dp_pend && hready) begin
            if (dp_beat < 16) tr_data[dp_beat] = hwdata;
            dp_pend = 0; err_phase = 0; last_dp_cyc = cyc;
         end
         if (htrans == 2'b10 && hready) begin
            if (n_tr < 16) begin
               tr_addr[n_tr] = haddr; tr_size[n_tr] = hsize; tr_cyc[n_tr] = cyc;
            end
            dp_beat = n_tr; n_tr++; dp_pend = 1; waits_left = wait_cfg;
         end
         if (done_valid) begin
            rsp_seen = 1; rsp_be = done_bus_err; rsp_ma = done_misalign;
            rsp_cyc = cyc; busy = 0;
         end
      end
   end

   int prev_last = -100;

   task automatic set_cfg(input logic [15:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_side_fx = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic do_store(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d,
                           input int w, input int ea, input bit nonidem);
      int szc, nb, exp_n, exp_log, t;
      bit unal, mis, split, exp_err;
      longint m, ed;
      string tg;
      szc = (sz > 2) ? 2 : int'(sz);
      nb = 1 << szc;
      unal = (a & (nb - 1)) != 0;
      mis = unal && nonidem;
      split = unal && !mis;
      exp_n = mis ? 0 : (split ? nb : 1);
      exp_err = (ea < exp_n);
      exp_log = exp_err ? ea + 1 : exp_n;
      tg = split ? "R2" : "R1";
      wait_cfg = w; err_at = ea; n_tr = 0; rsp_seen = 0; ready_viol = 0;
      @(negedge clk);
      while (!st_ready) @(negedge clk);
      st_valid = 1'b1; st_addr = a; st_size = sz; st_data = d;
      @(negedge clk);
      st_valid = 1'b0; busy = 1;
      t = 0;
      while (!rsp_seen && t < 100) begin @(negedge clk); t++; end
      #2;
      chk(rsp_seen, "R6", "response seen", rsp_seen, 1);
      chk(ready_viol == 0, "R8", "ready low while busy", ready_viol, 0);
      if (mis) begin
         chk(n_tr == 0, "R3", "no transfer on misalign", n_tr, 0);
         chk(rsp_ma == 1 && rsp_be == 0, "R3", "misalign flag", {rsp_ma, rsp_be}, 2);
      end else begin
         chk(n_tr == exp_log, tg, "transfer count", n_tr, exp_log);
         for (int k = 0; k < exp_log && k < n_tr && k < 16; k++) begin
            chk(tr_addr[k] == (split ? a + k : a), tg, "address", tr_addr[k], split ? a + k : a);
            chk(tr_size[k] == (split ? 3'd0 : 3'(szc)), "R4", "hsize", tr_size[k], split ? 0 : szc);
            if (!(exp_err && k == ea)) begin
               if (split) ed = ((longint'(d) >> (8*k)) & 64'hFF) << (8*((a + k) & 3));
               else begin
                  m = (nb == 4) ? 64'hFFFF_FFFF : ((64'd1 << (8*nb)) - 1);
                  ed = ((longint'(d) & m) << (8*(a & 3))) & 64'hFFFF_FFFF;
               end
               chk(tr_data[k] == ed[31:0], tg, "lane data", tr_data[k], ed);
            end
            if (k > 0)
               chk(tr_cyc[k] - tr_cyc[k-1] == 1 + w, "R9", "beat spacing",
                   tr_cyc[k] - tr_cyc[k-1], 1 + w);
         end
         if (n_tr > 0) begin
            chk(tr_cyc[0] - prev_last >= 2, "R1", "idle gap between stores",
                tr_cyc[0] - prev_last, 2);
            prev_last = tr_cyc[(n_tr < 16 ? n_tr : 16) - 1];
         end
         chk(rsp_be == exp_err, "R7", "bus error flag", rsp_be, exp_err);
         chk(rsp_ma == 0, "R3", "no misalign flag", rsp_ma, 0);
         chk(rsp_cyc == last_dp_cyc + 1, "R6", "response after final data phase",
             rsp_cyc, last_dp_cyc + 1);
      end
   endtask

   initial begin
      logic [31:0] d;
      logic [31:0] bases [3];
      logic [15:0] cfgs [2];
      int cnt;
      bases[0] = 32'h1000_0100; bases[1] = 32'h9000_01FC; bases[2] = 32'h4000_0000;
      cfgs[0] = 16'h0000; cfgs[1] = 16'h0202;
      cnt = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #2;
      chk(st_ready == 1'b1, "R8", "ready after reset", st_ready, 1);
      chk(htrans == 2'b00, "R8", "bus idle after reset", htrans, 0);
      chk(done_valid == 1'b0, "R8", "no response after reset", done_valid, 0);
      // R5: reset value makes region 15 idempotent, so this word splits
      do_store(32'hF000_0003, 2'd2, 32'h8765_4321, 0, 99, 0);
      // Sweep of sizes, offsets, regions, attribute values and wait states (R1 R2 R3 R4 R9)
      for (int c = 0; c < 2; c++) begin
         set_cfg(cfgs[c]);
         for (int b = 0; b < 3; b++)
            for (int sz = 0; sz < 4; sz++)
               for (int off = 0; off < 4; off++)
                  for (int w = 0; w < 2; w++) begin
                     logic [31:0] a;
                     a = bases[b] + off;
                     d = 32'hA1B2_C3D4 ^ (cnt * 32'h0103_0507);
                     cnt++;
                     do_store(a, 2'(sz), d, w, 99, cfgs[c][a[31:28]]);
                  end
      end
      // Error injection (R7)
      set_cfg(16'h0000);
      for (int e = 0; e < 4; e++)
         do_store(32'h1000_0101, 2'd2, 32'hDEAD_BEEF, 0, e, 0);
      do_store(32'h1000_0104, 2'd2, 32'h1357_9BDF, 0, 0, 0);
      do_store(32'h1000_0107, 2'd1, 32'h0000_55AA, 0, 1, 0);
      do_store(32'h1000_0108, 2'd2, 32'h2468_ACE0, 0, 99, 0);
      // Reconfiguration of one region between identical stores (R5)
      set_cfg(16'h0002);
      do_store(32'h1000_0002, 2'd2, 32'h0F1E_2D3C, 0, 99, 1);
      set_cfg(16'h0000);
      do_store(32'h1000_0002, 2'd2, 32'h0F1E_2D3C, 0, 99, 0);
      repeat (3) @(negedge clk);
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #(150000 * 5);
      if (!finished) begin
         finished = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule